// File: doc/BRIEF.md
# UART Bit-Rate Timing Generator

This block produces the timing strobes that a UART transmitter and receiver need. It runs on the instruction-cycle clock. A 16-bit divisor value sets the reload value of a down-counter. The counter spans divisor + 1 clocks. Each time it wraps, the block raises an oversample strobe for a single clock. A 4-bit sub-counter groups these strobes into bit times and raises a bit strobe once per bit. A bit time holds sixteen oversample periods in standard mode and four in fast mode.

Software-facing logic writes a new divisor through a one-cycle write strobe. The write restarts all timing at once, so a rate change never waits for a slow old period to run out. An enable input pauses the block without losing its place. As a worked figure, a 4 MHz clock in standard mode with divisor 25 gives 26 × 16 = 416 clocks per bit, which is about 9615 baud.

Top module: `uart_bitclk_gen`

## Requirements
- R1: After reset the divisor is 0, both counters are clear and standard mode is active. With enable high and no write, the oversample strobe is therefore high on every clock, and the first bit strobe comes on the 16th enabled clock.
- R2: The oversample strobe is high for exactly one clock out of every divisor + 1 enabled clocks.
- R3: In standard mode (fast select low when the bit time began), the bit strobe is high together with every 16th oversample strobe, so one bit lasts 16 × (divisor + 1) enabled clocks.
- R4: In fast mode (fast select high when the bit time began), the bit strobe is high together with every 4th oversample strobe, so one bit lasts 4 × (divisor + 1) enabled clocks.
- R5: A write stores the new divisor, reloads the down-counter with it, clears the sub-counter and takes the current fast select as the mode. Both strobes are low in the write cycle. The first oversample strobe follows on the (divisor + 1)-th enabled clock after the write.
- R6: A change of the fast select has no effect until the next bit strobe, or until a write.
- R7: While enable is low and no write is present, both strobes stay low and both counters hold their values. Timing resumes from the same point when enable returns.
- R8: Divisor 0 gives a bit every 16 clocks in standard mode and every 4 clocks in fast mode. Divisor 65535 gives one oversample strobe every 65536 clocks.
- R9: Divisor 25 in standard mode gives a bit strobe on the 416th enabled clock after the write.
- R10: The bit strobe is never high unless the oversample strobe is high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Count enable; low pauses both counters and both strobes |
| fast_sel | input | 1 | Rate select: 0 = 16 periods per bit, 1 = 4 periods per bit |
| div_wr | input | 1 | One-cycle divisor write strobe |
| div_wdata | input | 16 | Divisor value to write |
| os_tick | output | 1 | One-clock oversample strobe at each down-counter wrap |
| bit_tick | output | 1 | One-clock strobe once per bit time |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a 4-bit sub-counter and ratios of 16 and 4. The full 16-bit divisor width lets the bench reach the slowest rate, with a 65536-clock oversample period, inside one run. The narrow sub-counter makes the four-period fast bit, and the mode change at a bit boundary, come up often under random stimulus. Random runs use small divisors, so many bit boundaries, pauses and mid-bit writes occur. Directed runs cover the 416-clock bit and both divisor extremes.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FAST = 1'b1
  } rate_mode_e;

endpackage

// File: rtl/bitclk_divreg.sv
module bitclk_divreg #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] div_q
);

  logic [DIV_W-1:0] div_d;

  always_comb begin
    div_d = div_q;
    if (wr) div_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R5: the stored divisor changes only through a write
  a_r5_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(div_q));

  a_r5_div_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> div_q == $past(wdata));

endmodule

// File: rtl/bitclk_prescaler.sv
module bitclk_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] period,
  output logic             os_tick
);

  localparam logic [DIV_W-1:0] CNT_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign os_tick = en && !load && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (en) begin
      if (at_zero)     cnt_d = period;
      else             cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a wrap reloads the full period
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> cnt_q == $past(period));

  // R5: a write restarts the counter from the written value
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  // R7: paused counter holds
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt_q));

  // R7: no strobe while paused
  a_r7_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !os_tick);

endmodule

// File: rtl/bitclk_subdiv.sv
module bitclk_subdiv
  import bitclk_pkg::*;
#(
  parameter int SUB_W      = 4,
  parameter int SLOW_RATIO = 16,
  parameter int FAST_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic os_tick,
  input  logic fast_sel,
  output logic bit_tick
);

  localparam logic [SUB_W-1:0] SLOW_LAST = SUB_W'(SLOW_RATIO - 1);
  localparam logic [SUB_W-1:0] FAST_LAST = SUB_W'(FAST_RATIO - 1);
  localparam logic [SUB_W-1:0] SUB_ONE   = {{(SUB_W-1){1'b0}}, 1'b1};

  rate_mode_e       mode_q;
  rate_mode_e       mode_d;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] sub_d;
  logic [SUB_W-1:0] last_idx;
  logic             wrap;

  assign last_idx = (mode_q == MODE_FAST) ? FAST_LAST : SLOW_LAST;
  assign wrap     = os_tick && (sub_q == last_idx);
  assign bit_tick = wrap;

  always_comb begin
    sub_d  = sub_q;
    mode_d = mode_q;
    if (clear || wrap) begin
      sub_d  = '0;
      mode_d = fast_sel ? MODE_FAST : MODE_STD;
    end else if (os_tick) begin
      sub_d  = sub_q + SUB_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      mode_q <= MODE_STD;
    end else begin
      sub_q  <= sub_d;
      mode_q <= mode_d;
    end
  end

  // R3 / R4: the sub-counter never passes the last index of its mode
  a_r3_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= last_idx);

  // R6: mode moves only at a bit boundary or on a write
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !clear) |=> $stable(mode_q));

  // R5: a write clears the sub-counter
  a_r5_sub_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sub_q == '0);

endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen #(
  parameter int DIV_W      = 16,
  parameter int SUB_W      = 4,
  parameter int SLOW_RATIO = 16,
  parameter int FAST_RATIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_sel,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             os_tick,
  output logic             bit_tick
);

  logic [DIV_W-1:0] div_q;

  bitclk_divreg #(.DIV_W(DIV_W)) u_divreg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (div_wr),
    .wdata (div_wdata),
    .div_q (div_q)
  );

  bitclk_prescaler #(.DIV_W(DIV_W)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (div_wr),
    .load_val (div_wdata),
    .period   (div_q),
    .os_tick  (os_tick)
  );

  bitclk_subdiv #(
    .SUB_W      (SUB_W),
    .SLOW_RATIO (SLOW_RATIO),
    .FAST_RATIO (FAST_RATIO)
  ) u_subdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (div_wr),
    .os_tick  (os_tick),
    .fast_sel (fast_sel),
    .bit_tick (bit_tick)
  );

  // R10: a bit strobe always sits on an oversample strobe
  a_r10_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R5: nothing fires in a write cycle
  a_r5_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> !os_tick && !bit_tick);

endmodule

// File: tb/tb_uart_bitclk_gen.sv
module tb_uart_bitclk_gen;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic        fast_sel;
  logic        div_wr;
  logic [15:0] div_wdata;
  logic        os_tick;
  logic        bit_tick;

  int n_chk;
  int n_bad;

  int m_div;
  int m_ph;
  int m_sub;
  bit m_fast;

  uart_bitclk_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fast_sel  (fast_sel),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .os_tick   (os_tick),
    .bit_tick  (bit_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int last_of(input bit fast);
    return fast ? 3 : 15;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model at posedge
  task automatic cyc(input bit e, input bit hs, input bit w, input logic [15:0] wd,
                     output bit got_os, output bit got_bit);
    bit eos;
    bit ebit;
    string tg;
    en = e; fast_sel = hs; div_wr = w; div_wdata = wd;
    #3;
    eos  = e && !w && (m_ph == 0);
    ebit = eos && (m_sub == last_of(m_fast));
    if (w)       tg = "R5";
    else if (!e) tg = "R7";
    else         tg = "R2";
    chk(os_tick == eos, tg, os_tick, eos);
    if (w)           tg = "R5";
    else if (!e)     tg = "R7";
    else if (m_fast) tg = "R4";
    else             tg = "R3";
    chk(bit_tick == ebit, tg, bit_tick, ebit);
    chk(!(bit_tick && !os_tick), "R10", bit_tick, 0);
    got_os  = os_tick;
    got_bit = bit_tick;
    @(posedge clk);
    if (w) begin
      m_div = int'(wd); m_ph = int'(wd); m_sub = 0; m_fast = hs;
    end else if (e) begin
      if (m_ph == 0) begin
        m_ph = m_div;
        if (m_sub == last_of(m_fast)) begin m_sub = 0; m_fast = hs; end
        else m_sub++;
      end else m_ph--;
    end
    @(negedge clk);
  endtask

  // enabled clocks until the first bit strobe (1-based), 0 if none within lim
  task automatic run_to_bit(input bit hs, input int lim, output int n);
    bit o, b;
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      cyc(1'b1, hs, 1'b0, 16'd0, o, b);
      if (b) begin n = i; break; end
    end
  endtask

  task automatic run_to_os(input int lim, output int n);
    bit o, b;
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 16'd0, o, b);
      if (o) begin n = i; break; end
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit o, b;
    int n;
    bit hs;
    n_chk = 0; n_bad = 0;
    m_div = 0; m_ph = 0; m_sub = 0; m_fast = 1'b0;
    rst_n = 1'b0; en = 1'b0; fast_sel = 1'b0; div_wr = 1'b0; div_wdata = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, divisor 0, standard mode
    cyc(1'b1, 1'b0, 1'b0, 16'd0, o, b);
    chk(o == 1'b1, "R1", o, 1);
    run_to_bit(1'b0, 40, n);
    chk(n == 15, "R1", n, 15);

    // R8: divisor 0, fast mode after write
    cyc(1'b1, 1'b1, 1'b1, 16'd0, o, b);
    run_to_bit(1'b1, 40, n);
    chk(n == 4, "R8", n, 4);
    run_to_bit(1'b1, 40, n);
    chk(n == 4, "R8", n, 4);

    // R6: switching to standard mid-bit waits for the boundary
    cyc(1'b1, 1'b0, 1'b0, 16'd0, o, b);
    run_to_bit(1'b0, 40, n);
    chk(n == 3, "R6", n, 3);
    run_to_bit(1'b0, 40, n);
    chk(n == 16, "R6", n, 16);

    // R9: divisor 25, standard mode
    cyc(1'b1, 1'b0, 1'b1, 16'd25, o, b);
    run_to_bit(1'b0, 1000, n);
    chk(n == 416, "R9", n, 416);
    run_to_bit(1'b0, 1000, n);
    chk(n == 416, "R9", n, 416);

    // R5: mid-period rewrite restarts at once
    repeat (7) cyc(1'b1, 1'b0, 1'b0, 16'd0, o, b);
    cyc(1'b1, 1'b0, 1'b1, 16'd9, o, b);
    run_to_os(100, n);
    chk(n == 10, "R5", n, 10);

    // R7: pause holds position
    cyc(1'b1, 1'b0, 1'b1, 16'd5, o, b);
    repeat (3) cyc(1'b1, 1'b0, 1'b0, 16'd0, o, b);
    repeat (20) cyc(1'b0, 1'b0, 1'b0, 16'd0, o, b);
    run_to_os(100, n);
    chk(n == 3, "R7", n, 3);

    // R8: divisor 65535
    cyc(1'b1, 1'b0, 1'b1, 16'hFFFF, o, b);
    run_to_os(70000, n);
    chk(n == 65536, "R8", n, 65536);

    // random mix
    hs = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 16'd2, o, b);
    for (int i = 0; i < 30000; i++) begin
      bit e, w;
      logic [15:0] wd;
      if (($urandom % 100) == 0) hs = ~hs;
      e  = (($urandom % 8) != 0);
      w  = (($urandom % 300) == 0);
      wd = 16'(($urandom % 4 == 0) ? ($urandom % 40) : ($urandom % 4));
      cyc(e, hs, w, wd, o, b);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule